// File: doc/BRIEF.md
# Display Link Generic Command Packet Front End

This block sits between a processor's register bus and the packet layer of a display serial link host. Software queues a command by first writing all of its payload bytes, packed four to a 32-bit word, into a data register, and then writing a 32-bit header word into a header register. The header write starts the packet. A simple packet emitter takes headers from the command FIFO one at a time and sends the header bytes as a byte stream. For a long packet it then sends the payload bytes taken from the write-payload FIFO. Responses from the link side come back as 32-bit words into a read-payload FIFO, and software pops them by reading the data register.

A status register shows the empty and full flags of all three FIFOs, a read-busy flag, and sticky overflow flags. Software treats a transfer as complete once the command FIFO and the write-payload FIFO are both empty. For a read request, software waits for read-busy to clear and then pops one word for every four response bytes. Lane serialization, ECC and CRC generation, and the PHY are not part of this block.

Top module: `gpkt_cmd_if`

## Requirements
- R1: The status register (address 0x8) reports: bit0 command FIFO empty, bit1 command FIFO full, bit2 write-payload FIFO empty, bit3 write-payload FIFO full, bit4 read-payload FIFO empty, bit5 read-payload FIFO full, bit6 read busy, bit7 command overflow, bit8 write-payload overflow, bit9 read-payload overflow. All other bits read as zero.
- R2: A register write to address 0x0 pushes the data word into the command FIFO. A write to address 0x4 pushes it into the write-payload FIFO. A read of address 0x4 pops the read-payload FIFO. A read of any address other than 0x4 or 0x8 returns zero.
- R3: Each packet begins with three header bytes in this order: bits 7:0 (data type), bits 15:8, bits 23:16. Start-of-packet marks the first byte and end-of-packet marks the last byte. No two packets overlap.
- R4: A data type whose low nibble is 0x9 marks a long packet. Its header bits 23:8 give a byte count N. The N payload bytes follow the header, taken little-endian from successive payload words (byte j of a word is bits 8j+7:8j). The unused upper bytes of a final partial word are discarded along with that word. A long packet with N = 0 has only the header.
- R5: When a payload byte is due and the write-payload FIFO is empty, the output stays invalid. Sending resumes with the next byte once a word arrives, with no byte lost or repeated.
- R6: Once a packet's last byte has been sent, and no further command is queued, both the command-empty and write-payload-empty flags read as 1.
- R7: Read busy is set by an accepted header write whose data type is 0x04, 0x14, 0x24 or 0x06. It is cleared by a pulse on rsp_done. If both happen at the same edge, the set wins.
- R8: Each rsp_valid pulse pushes rsp_word into the read-payload FIFO. Words are returned in order and unaltered. A pop from an empty FIFO returns zero and changes nothing.
- R9: A push into a full FIFO with no pop at the same edge is dropped. It sets that FIFO's overflow flag, which stays set until reset.
- R10: Each FIFO holds 16 words, and its full flag is set exactly when it holds 16.
- R11: Reset empties all FIFOs, clears read busy and the overflow flags, and returns the emitter to idle.
- R12: A push and a pop on the same FIFO at the same edge both take effect, even when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| rsp_valid | input | 1 | Response word push from the link side |
| rsp_word | input | 32 | Response word |
| rsp_done | input | 1 | Response fully captured; clears read busy |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |

## Verification
Several pairs of events can land on the same clock edge. A header write can meet the emitter's pop of a full command FIFO. A response push can meet a software pop of a full read FIFO. A read-request header can arrive with the rsp_done pulse that would clear busy. The bench provokes the first pair by stalling the emitter on a missing payload word, filling the command FIFO, and then releasing the stall while headers are written every cycle. It provokes the other two by driving both strobes in one cycle. A queue-based reference model, stepped every clock, judges acceptance, drops, overflow flags and busy, and the output stream is compared against it on every cycle.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;

  localparam int WORD_W = 32;

  // register byte offsets
  localparam logic [3:0] ADDR_HDR  = 4'h0;
  localparam logic [3:0] ADDR_DATA = 4'h4;
  localparam logic [3:0] ADDR_STAT = 4'h8;

  typedef enum logic [1:0] {
    EM_IDLE,
    EM_HDR,
    EM_PLD
  } em_state_t;

  typedef struct packed {
    logic [7:0]  rsvd;
    logic [15:0] wc;
    logic [7:0]  dt;
  } pkt_hdr_t;

  // long packet when the low nibble of the data type is 9
  function automatic logic dt_is_long(input logic [7:0] dt);
    return dt[3:0] == 4'h9;
  endfunction

  // data types that request a response
  function automatic logic dt_is_read(input logic [7:0] dt);
    return (dt == 8'h04) || (dt == 8'h14) || (dt == 8'h24) || (dt == 8'h06);
  endfunction

  // little-endian byte lane of a 32-bit word
  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

endpackage

// File: rtl/gpkt_fifo.sv
module gpkt_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         push_ok
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic          pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

endmodule

// File: rtl/gpkt_emitter.sv
module gpkt_emitter
  import gpkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_empty,
  input  logic [31:0] cmd_head,
  output logic        cmd_pop,
  input  logic        pld_empty,
  input  logic [31:0] pld_head,
  output logic        pld_pop,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        stall
);

  em_state_t   state;
  pkt_hdr_t    hdr;
  logic [1:0]  bidx;
  logic [1:0]  lane;
  logic [15:0] remain;
  logic        has_pld;

  assign has_pld = dt_is_long(hdr.dt) && (hdr.wc != 16'd0);

  always_comb begin
    cmd_pop  = 1'b0;
    pld_pop  = 1'b0;
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    tx_sop   = 1'b0;
    tx_eop   = 1'b0;
    stall    = 1'b0;
    case (state)
      EM_IDLE: cmd_pop = !cmd_empty;
      EM_HDR: begin
        tx_valid = 1'b1;
        tx_data  = word_byte(hdr, bidx);
        tx_sop   = (bidx == 2'd0);
        tx_eop   = (bidx == 2'd2) && !has_pld;
      end
      EM_PLD: begin
        if (pld_empty) begin
          stall = 1'b1;
        end else begin
          tx_valid = 1'b1;
          tx_data  = word_byte(pld_head, lane);
          tx_eop   = (remain == 16'd1);
          pld_pop  = (lane == 2'd3) || (remain == 16'd1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= EM_IDLE;
      hdr    <= '0;
      bidx   <= '0;
      lane   <= '0;
      remain <= '0;
    end else begin
      case (state)
        EM_IDLE: begin
          if (cmd_pop) begin
            hdr   <= cmd_head;
            bidx  <= 2'd0;
            state <= EM_HDR;
          end
        end
        EM_HDR: begin
          bidx <= bidx + 2'd1;
          if (bidx == 2'd2) begin
            if (has_pld) begin
              state  <= EM_PLD;
              remain <= hdr.wc;
              lane   <= 2'd0;
            end else begin
              state <= EM_IDLE;
            end
          end
        end
        EM_PLD: begin
          if (tx_valid) begin
            lane   <= lane + 2'd1;
            remain <= remain - 16'd1;
            if (remain == 16'd1) state <= EM_IDLE;
          end
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gpkt_cmd_if.sv
module gpkt_cmd_if
  import gpkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_word,
  input  logic          rsp_done,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop
);

  // decoded register events
  logic hdr_wr, dat_wr, dat_rd, hdr_is_read;
  assign hdr_wr      = reg_wr && (reg_addr == AW'(ADDR_HDR));
  assign dat_wr      = reg_wr && (reg_addr == AW'(ADDR_DATA));
  assign dat_rd      = reg_rd && (reg_addr == AW'(ADDR_DATA));
  assign hdr_is_read = dt_is_read(reg_wdata[7:0]);

  logic [31:0] cmd_head, pld_head, rd_head;
  logic cmd_empty, cmd_full, cmd_push_ok, cmd_pop;
  logic pld_empty, pld_full, pld_push_ok, pld_pop;
  logic rd_empty, rd_full, rd_push_ok;
  logic em_stall;

  gpkt_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_cmd_fifo (
    .clk(clk), .rst_n(rst_n), .push(hdr_wr), .pop(cmd_pop), .din(reg_wdata),
    .head(cmd_head), .empty(cmd_empty), .full(cmd_full), .push_ok(cmd_push_ok)
  );

  gpkt_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_pld_fifo (
    .clk(clk), .rst_n(rst_n), .push(dat_wr), .pop(pld_pop), .din(reg_wdata),
    .head(pld_head), .empty(pld_empty), .full(pld_full), .push_ok(pld_push_ok)
  );

  gpkt_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rd_fifo (
    .clk(clk), .rst_n(rst_n), .push(rsp_valid), .pop(dat_rd), .din(rsp_word),
    .head(rd_head), .empty(rd_empty), .full(rd_full), .push_ok(rd_push_ok)
  );

  gpkt_emitter u_emitter (
    .clk(clk), .rst_n(rst_n),
    .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
    .pld_empty(pld_empty), .pld_head(pld_head), .pld_pop(pld_pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .stall(em_stall)
  );

  // drop events, brought out for the checker
  logic cmd_drop, pld_drop, rd_drop, busy_set;
  assign cmd_drop = hdr_wr && !cmd_push_ok;
  assign pld_drop = dat_wr && !pld_push_ok;
  assign rd_drop  = rsp_valid && !rd_push_ok;
  assign busy_set = cmd_push_ok && hdr_is_read;

  logic ovf_cmd, ovf_pld, ovf_rd, rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_cmd <= 1'b0;
      ovf_pld <= 1'b0;
      ovf_rd  <= 1'b0;
      rd_busy <= 1'b0;
    end else begin
      if (cmd_drop) ovf_cmd <= 1'b1;
      if (pld_drop) ovf_pld <= 1'b1;
      if (rd_drop)  ovf_rd  <= 1'b1;
      if (busy_set)      rd_busy <= 1'b1;
      else if (rsp_done) rd_busy <= 1'b0;
    end
  end

  logic [31:0] status;
  assign status = {22'd0, ovf_rd, ovf_pld, ovf_cmd, rd_busy,
                   rd_full, rd_empty, pld_full, pld_empty, cmd_full, cmd_empty};

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_rd) begin
      if (reg_addr == AW'(ADDR_STAT))      reg_rdata = status;
      else if (dat_rd && !rd_empty)        reg_rdata = rd_head;
    end
  end

endmodule

// File: rtl/gpkt_cmd_if_chk.sv
module gpkt_cmd_if_chk (
  input logic clk,
  input logic rst_n,
  input logic hdr_wr,
  input logic hdr_is_read,
  input logic cmd_push_ok,
  input logic cmd_full,
  input logic cmd_pop,
  input logic rsp_done,
  input logic rd_busy,
  input logic ovf_cmd,
  input logic ovf_pld,
  input logic ovf_rd,
  input logic tx_valid,
  input logic tx_sop,
  input logic tx_eop,
  input logic [31:0] status
);

  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && cmd_push_ok && hdr_is_read |=> status[6]);

  // R7
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !(hdr_wr && cmd_push_ok && hdr_is_read) |=> !rd_busy);

  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ovf_cmd) && !$fell(ovf_pld) && !$fell(ovf_rd));

  // R9
  cmd_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && cmd_full && !cmd_pop |=> ovf_cmd);

  // R3
  sop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> !$past(tx_valid && !tx_eop));

  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]) && !(status[2] && status[3]) && !(status[4] && status[5]));

endmodule

bind gpkt_cmd_if gpkt_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_is_read(hdr_is_read),
  .cmd_push_ok(cmd_push_ok), .cmd_full(cmd_full), .cmd_pop(cmd_pop),
  .rsp_done(rsp_done), .rd_busy(rd_busy), .ovf_cmd(ovf_cmd), .ovf_pld(ovf_pld),
  .ovf_rd(ovf_rd), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .status(status)
);

// File: tb/test_gpkt_cmd_if.sv
`timescale 1ns/1ps
module test_gpkt_cmd_if;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic rsp_valid = 1'b0, rsp_done = 1'b0;
  logic [31:0] rsp_word = 32'h0;
  logic tx_valid, tx_sop, tx_eop;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  gpkt_cmd_if i_gpkt_cmd_if (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .rsp_done(rsp_done), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mq_cmd[$], mq_pld[$], mq_rd[$];
  bit m_ovc, m_ovp, m_ovr, m_busy, m_act;
  logic [31:0] m_hdr;
  int m_pos, m_len;

  function automatic logic [31:0] m_status();
    return {22'd0, m_ovr, m_ovp, m_ovc, m_busy,
            mq_rd.size() == 16, mq_rd.size() == 0,
            mq_pld.size() == 16, mq_pld.size() == 0,
            mq_cmd.size() == 16, mq_cmd.size() == 0};
  endfunction

  function automatic logic [10:0] m_tx();
    if (!m_act) return 11'd0;
    if (m_pos < 3)
      return {1'b1, m_pos == 0, m_pos == m_len - 1, 8'(m_hdr >> (8 * m_pos))};
    if (mq_pld.size() == 0) return 11'd0;
    return {1'b1, 1'b0, m_pos == m_len - 1, 8'(mq_pld[0] >> (8 * ((m_pos - 3) % 4)))};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_cmd.delete(); mq_pld.delete(); mq_rd.delete();
      m_ovc = 0; m_ovp = 0; m_ovr = 0; m_busy = 0; m_act = 0; m_pos = 0; m_len = 0;
    end else begin
      bit bset;
      bset = 0;
      // emitter step
      if (!m_act) begin
        if (mq_cmd.size() > 0) begin
          m_hdr = mq_cmd.pop_front();
          m_act = 1; m_pos = 0;
          m_len = 3 + ((m_hdr[3:0] == 4'h9) ? int'(m_hdr[23:8]) : 0);
        end
      end else if (m_pos < 3) begin
        m_pos++;
        if (m_pos == m_len) m_act = 0;
      end else if (mq_pld.size() > 0) begin
        if (((m_pos - 3) % 4) == 3 || m_pos == m_len - 1) void'(mq_pld.pop_front());
        m_pos++;
        if (m_pos == m_len) m_act = 0;
      end
      // software pop of read data
      if (reg_rd && reg_addr == 4'h4 && mq_rd.size() > 0) void'(mq_rd.pop_front());
      // pushes after pops
      if (reg_wr && reg_addr == 4'h0) begin
        if (mq_cmd.size() < 16) begin
          mq_cmd.push_back(reg_wdata);
          if (reg_wdata[7:0] inside {8'h04, 8'h14, 8'h24, 8'h06}) bset = 1;
        end else m_ovc = 1;
      end
      if (reg_wr && reg_addr == 4'h4) begin
        if (mq_pld.size() < 16) mq_pld.push_back(reg_wdata); else m_ovp = 1;
      end
      if (rsp_valid) begin
        if (mq_rd.size() < 16) mq_rd.push_back(rsp_word); else m_ovr = 1;
      end
      if (bset) m_busy = 1; else if (rsp_done) m_busy = 0;
    end
  end

  // per-cycle comparison and output capture
  logic [7:0] txlog[$];
  always @(negedge clk) begin
    n_cyc++;
    if (rst_n) begin
      check("R3/R4/R5 tx stream vs model", {21'd0, tx_valid, tx_sop, tx_eop, tx_data}, {21'd0, m_tx()});
      if (reg_rd) begin
        logic [31:0] e;
        e = 32'd0;
        if (reg_addr == 4'h8) e = m_status();
        else if (reg_addr == 4'h4 && mq_rd.size() > 0) e = mq_rd[0];
        check("R1/R8 rdata vs model", reg_rdata, e);
      end
      if (tx_valid) txlog.push_back(tx_data);
    end
  end

  // ---------------- stimulus helpers (drive just after posedge) ----------------
  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask
  task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); check(tag, reg_rdata, exp);
    step(); reg_rd = 0;
  endtask
  task automatic rsp(input logic [31:0] w);
    rsp_valid = 1; rsp_word = w; step(); rsp_valid = 0;
  endtask
  task automatic done_pulse(); rsp_done = 1; step(); rsp_done = 0; endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_up();
  end

  initial begin
    idle(3);
    rst_n = 1;
    step();
    // R11 / R1 reset state
    rdchk(4'h8, 32'h15, "R11 reset status");
    // R2 header address does not read back
    rdchk(4'h0, 32'h0, "R2 other address reads zero");

    // R3 short packet
    txlog.delete();
    wr(4'h0, 32'h0034_1205);
    idle(6);
    check("R3 short size", txlog.size(), 3);
    check("R3 short bytes", {8'h0, txlog[0], txlog[1], txlog[2]}, 32'h0005_1234);
    rdchk(4'h8, 32'h15, "R6 complete after short");

    // R4 long packet with partial final word
    txlog.delete();
    wr(4'h4, 32'h4433_2211);
    wr(4'h4, 32'h0000_6655);
    wr(4'h0, 32'h0000_0639);
    idle(14);
    check("R4 long size", txlog.size(), 9);
    check("R4 long first payload", {txlog[3], txlog[4], txlog[5], txlog[6]}, 32'h1122_3344);
    check("R4 long tail", {16'h0, txlog[7], txlog[8]}, 32'h0000_5566);
    rdchk(4'h8, 32'h15, "R6 complete after long");

    // R5 stall when payload missing
    txlog.delete();
    wr(4'h0, 32'h0000_0529);
    idle(10);
    check("R5 only header during stall", txlog.size(), 3);
    wr(4'h4, 32'h0403_0201);
    idle(4);
    check("R5 first word sent", txlog.size(), 7);
    wr(4'h4, 32'h0000_0005);
    idle(4);
    check("R5 resumed byte", {24'h0, txlog[7]}, 32'h05);
    check("R5 total", txlog.size(), 8);

    // R7 / R8 read path
    wr(4'h0, 32'h0000_0B06);
    idle(5);
    rdchk(4'h8, 32'h55, "R7 busy set after read header");
    rsp(32'hDDCC_BBAA);
    rsp(32'h0000_00EE);
    done_pulse();
    rdchk(4'h8, 32'h05, "R7 busy cleared by rsp_done");
    rdchk(4'h4, 32'hDDCC_BBAA, "R8 first response word");
    rdchk(4'h4, 32'h0000_00EE, "R8 second response word");
    rdchk(4'h4, 32'h0, "R8 empty pop returns zero");
    rdchk(4'h8, 32'h15, "R8 empty pop changes nothing");

    // R7 set wins over clear at the same edge
    reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'h0000_0014; rsp_done = 1;
    step(); reg_wr = 0; rsp_done = 0;
    idle(5);
    rdchk(4'h8, 32'h55, "R7 set wins");
    done_pulse();
    rdchk(4'h8, 32'h15, "R7 cleared later");

    // R9 / R10 payload FIFO overflow
    for (int i = 0; i < 17; i++) wr(4'h4, 32'(i + 1));
    rdchk(4'h8, 32'h119, "R9/R10 payload full and overflow");
    txlog.delete();
    wr(4'h0, 32'h0000_4029);
    idle(80);
    check("R10 sixteen words sent", txlog.size(), 67);
    check("R4 word 16 byte 0", {24'h0, txlog[63]}, 32'd16);
    rdchk(4'h8, 32'h115, "R9 payload overflow sticky");

    // R9 / R10 / R12 command FIFO overflow and release under pressure
    wr(4'h0, 32'h0000_0429);
    idle(6);
    for (int i = 0; i < 17; i++) wr(4'h0, {16'h0, 8'(i), 8'h05});
    rdchk(4'h8, 32'h196, "R9/R10 command full and overflow");
    wr(4'h4, 32'hA1A2_A3A4);
    for (int i = 0; i < 12; i++) wr(4'h0, {16'h0, 8'(i + 32), 8'h05});
    idle(120);
    rdchk(4'h8, 32'h195, "R12 command drained");

    // R12 read FIFO push and pop at the same edge while full
    for (int i = 0; i < 16; i++) rsp(32'hA0 + 32'(i));
    rsp_valid = 1; rsp_word = 32'hB0; reg_rd = 1; reg_addr = 4'h4;
    @(negedge clk); check("R12 head while simultaneous", reg_rdata, 32'hA0);
    step(); rsp_valid = 0; reg_rd = 0;
    rdchk(4'h8, 32'h1A5, "R12 push accepted at pop edge");
    rsp(32'hC0);
    rdchk(4'h8, 32'h3A5, "R9 read overflow");
    for (int i = 1; i < 16; i++) rdchk(4'h4, 32'hA0 + 32'(i), "R8 ordered response");
    rdchk(4'h4, 32'hB0, "R12 late word kept");
    rdchk(4'h8, 32'h395, "R9 flags after drain");

    // R11 reset mid-run
    wr(4'h4, 32'h1);
    rst_n = 0; idle(2); rst_n = 1; step();
    rdchk(4'h8, 32'h15, "R11 reset clears all");

    finish_up();
  end

endmodule